// File: doc/BRIEF.md
# Selectable Clock Divider Bank

This block turns one fast source clock into three divided clocks for a clock generator. The fast clock stands in for a frequency synthesizer output. Two output banks, A and B, each choose one of four integer ratios through their own 2-bit select. A third divider, the feedback divider, has its own 2-bit select and drives two outputs. One is the feedback clock, which a phase detector outside this block compares with the reference. The other is a reference-rate clock for downstream logic.

Two reference clocks can also feed the dividers, either an external reference or a crystal-oscillator clock. In bypass mode the selected reference replaces the fast clock as the divider input, so the outputs run at divided reference rates. An active-high master reset stops every divider and forces every output low at once. On release, all dividers start on the same input edge, so every output begins in phase.

Every ratio gives a 50% duty cycle, measured in half-periods of the divider input clock. This includes the odd ratio of 3, which uses logic on both input edges. A select may change while the block runs. The new ratio is taken up only at the end of the current output period.

Top module: `selclk_divbank`

## Requirements
- R1: Bank A select `sel_a` picks the ratio: 2'b00 divide by 3, 2'b01 divide by 4, 2'b10 divide by 6, 2'b11 divide by 12.
- R2: Bank B decodes `sel_b` with the same table as R1, independently of bank A, so the two banks can run different ratios at the same time.
- R3: The feedback select `sel_fb` picks the ratio of `clk_fb`: 2'b00 divide by 12, 2'b01 divide by 16, 2'b10 divide by 20, 2'b11 divide by 24.
- R4: `clk_ref` runs at the feedback ratio and is in phase with `clk_fb`.
- R5: While `mst_rst` is 1, all four outputs are 0, including in the same instant the reset rises. All dividers are cleared on each rising edge of the divider input clock while `mst_rst` is 1.
- R6: With `pll_en` = 1 the dividers count `vco_clk`. With `pll_en` = 0 (bypass) they count the selected reference clock instead.
- R7: `osc_sel` = 1 selects `osc_clk` as the reference clock, and `osc_sel` = 0 selects `ext_ref_clk`.
- R8: For a ratio N, every output period is high for exactly N half-periods and low for exactly N half-periods of the divider input clock. This holds for odd and even N.
- R9: On the first rising edge of the divider input clock that samples `mst_rst` low, all four outputs rise together.
- R10: A select change is sampled only when the output period in progress ends. That period completes at the old ratio, and the next period uses the new ratio, with no shortened high or low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco_clk | input | 1 | Fast source clock used when `pll_en` is 1 |
| ext_ref_clk | input | 1 | External reference clock |
| osc_clk | input | 1 | Crystal-oscillator reference clock |
| osc_sel | input | 1 | 1 selects `osc_clk`, 0 selects `ext_ref_clk` as the reference |
| pll_en | input | 1 | 1 divides `vco_clk`, 0 divides the selected reference (bypass) |
| mst_rst | input | 1 | Active-high master reset, synchronous to the divider input clock |
| sel_a | input | 2 | Bank A ratio select |
| sel_b | input | 2 | Bank B ratio select |
| sel_fb | input | 2 | Feedback divider ratio select |
| clk_a | output | 1 | Bank A divided clock |
| clk_b | output | 1 | Bank B divided clock |
| clk_fb | output | 1 | Feedback divided clock |
| clk_ref | output | 1 | Reference-rate divided clock, same ratio and phase as `clk_fb` |

## Verification
The bench measures every output in half-periods of whichever clock the mux selects. It goes after four kinds of error:
- Divide-by-3: a design without the falling-edge stage would give a 2/4 split instead of 3/3.
- Each select code: a swapped decode table would show wrong period lengths.
- Bypass, with each reference in turn: a design that still counted the fast clock, or used the wrong reference, would give periods of the wrong length.
- A change from divide-by-3 to divide-by-12 right after a rising edge: a design that reloaded at once would cut the running period short or stretch it, instead of finishing three half-periods high and three low.

After each reset release, the bench checks that all outputs rise on the first input edge. During reset it checks that they stay low.

// File: rtl/selclk_pkg.sv
package selclk_pkg;

    localparam int SEL_W     = 2;
    localparam int NUM_SEL   = 2 ** SEL_W;
    localparam int NUM_BANKS = 2;
    localparam int RATIO_W   = 6;

    typedef logic [RATIO_W-1:0] ratio_t;
    typedef logic [NUM_SEL-1:0][RATIO_W-1:0] ratio_tab_t;

    // Index 0 is the lowest entry (select code 2'b00).
    localparam ratio_tab_t BANK_TAB_DFLT = {ratio_t'(12), ratio_t'(6), ratio_t'(4), ratio_t'(3)};
    localparam ratio_tab_t FDBK_TAB_DFLT = {ratio_t'(24), ratio_t'(20), ratio_t'(16), ratio_t'(12)};

    // Divider state: down counter, active ratio, odd flag, rising-edge phase.
    typedef struct packed {
        ratio_t left;
        ratio_t ratio;
        logic   odd;
        logic   hi;
    } div_state_t;

    // Counter values at or above this keep the rising-edge phase high.
    function automatic ratio_t high_thresh(ratio_t n);
        logic [RATIO_W:0] w;
        w = {1'b0, n} + 1'b1;
        return w[RATIO_W:1];
    endfunction

endpackage

// File: rtl/selclk_srcmux.sv
module selclk_srcmux (
    input  logic vco_clk,
    input  logic ext_clk,
    input  logic osc_clk,
    input  logic osc_sel,
    input  logic pll_en,
    output logic div_clk
);

    logic ref_clk;

    assign ref_clk = osc_sel ? osc_clk : ext_clk;
    assign div_clk = pll_en  ? vco_clk : ref_clk;

endmodule

// File: rtl/selclk_ratio_div.sv
module selclk_ratio_div
    import selclk_pkg::*;
#(
    parameter ratio_tab_t TAB = BANK_TAB_DFLT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic             div_out
);

    div_state_t st_q;
    div_state_t st_d;
    ratio_t     pick;
    logic       hi_lag_q;

    assign pick = TAB[sel];

    // Reload only at terminal count, so a select change never cuts a period.
    always_comb begin
        st_d = st_q;
        if (st_q.left == '0) begin
            st_d.ratio = pick;
            st_d.left  = pick - 1'b1;
            st_d.odd   = pick[0];
            st_d.hi    = 1'b1;
        end else begin
            st_d.left = st_q.left - 1'b1;
            st_d.hi   = (st_q.left - 1'b1) >= high_thresh(st_q.ratio);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Half-period stretch for odd ratios.
    always_ff @(negedge clk) begin
        if (rst) begin
            hi_lag_q <= 1'b0;
        end else begin
            hi_lag_q <= st_q.hi;
        end
    end

    assign div_out = st_q.hi | (st_q.odd & hi_lag_q);

endmodule

// File: rtl/selclk_divbank.sv
module selclk_divbank
    import selclk_pkg::*;
#(
    parameter ratio_tab_t BANK_TAB = BANK_TAB_DFLT,
    parameter ratio_tab_t FDBK_TAB = FDBK_TAB_DFLT
) (
    input  logic             vco_clk,
    input  logic             ext_ref_clk,
    input  logic             osc_clk,
    input  logic             osc_sel,
    input  logic             pll_en,
    input  logic             mst_rst,
    input  logic [SEL_W-1:0] sel_a,
    input  logic [SEL_W-1:0] sel_b,
    input  logic [SEL_W-1:0] sel_fb,
    output logic             clk_a,
    output logic             clk_b,
    output logic             clk_fb,
    output logic             clk_ref
);

    logic                              div_clk;
    logic [NUM_BANKS-1:0][SEL_W-1:0]   bank_sel;
    logic [NUM_BANKS-1:0]              bank_div;
    logic                              fdbk_div;

    assign bank_sel = {sel_b, sel_a};

    selclk_srcmux u_srcmux (
        .vco_clk (vco_clk),
        .ext_clk (ext_ref_clk),
        .osc_clk (osc_clk),
        .osc_sel (osc_sel),
        .pll_en  (pll_en),
        .div_clk (div_clk)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        selclk_ratio_div #(.TAB(BANK_TAB)) u_div (
            .clk     (div_clk),
            .rst     (mst_rst),
            .sel     (bank_sel[g]),
            .div_out (bank_div[g])
        );
    end

    selclk_ratio_div #(.TAB(FDBK_TAB)) u_fdbk_div (
        .clk     (div_clk),
        .rst     (mst_rst),
        .sel     (sel_fb),
        .div_out (fdbk_div)
    );

    // Outputs are forced low for the whole time reset is high.
    assign clk_a   = bank_div[0] & ~mst_rst;
    assign clk_b   = bank_div[1] & ~mst_rst;
    assign clk_fb  = fdbk_div    & ~mst_rst;
    assign clk_ref = fdbk_div    & ~mst_rst;

endmodule

// File: rtl/selclk_divbank_chk.sv
module selclk_divbank_chk
    import selclk_pkg::*;
#(
    parameter ratio_tab_t BANK_TAB = BANK_TAB_DFLT,
    parameter ratio_tab_t FDBK_TAB = FDBK_TAB_DFLT
) (
    input logic clk,
    input logic rst,
    input logic clk_a,
    input logic clk_b,
    input logic clk_fb,
    input logic clk_ref
);

    localparam int PW   = RATIO_W + 1;
    localparam int NMON = 3;

    logic [NMON-1:0]         obs;
    logic [NMON-1:0]         prev_q;
    logic [NMON-1:0]         seen_q;
    logic [NMON-1:0]         rise;
    logic [NMON-1:0]         legal;
    logic [NMON-1:0][PW-1:0] per_q;

    assign obs  = {clk_fb, clk_b, clk_a};
    assign rise = obs & ~prev_q;

    always_comb begin
        legal = '0;
        for (int i = 0; i < NMON; i++) begin
            for (int s = 0; s < NUM_SEL; s++) begin
                if (i == NMON - 1) begin
                    if (per_q[i] == {1'b0, FDBK_TAB[s]}) legal[i] = 1'b1;
                end else begin
                    if (per_q[i] == {1'b0, BANK_TAB[s]}) legal[i] = 1'b1;
                end
            end
        end
    end

    // Input-clock rising edges between successive output rises.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            seen_q <= '0;
            per_q  <= '0;
        end else begin
            prev_q <= obs;
            for (int i = 0; i < NMON; i++) begin
                if (rise[i]) begin
                    seen_q[i] <= 1'b1;
                    per_q[i]  <= PW'(1);
                end else if (per_q[i] != '1) begin
                    per_q[i] <= per_q[i] + 1'b1;
                end
            end
        end
    end

    AST_RST_LOW: assert property (@(posedge clk) rst |-> !(clk_a || clk_b || clk_fb || clk_ref)); // R5

    AST_START_ALIGN: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |=> (clk_a && clk_b && clk_fb && clk_ref)); // R9

    AST_A_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (rise[0] && seen_q[0]) |-> legal[0]); // R1

    AST_B_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (rise[1] && seen_q[1]) |-> legal[1]); // R2

    AST_FB_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (rise[2] && seen_q[2]) |-> legal[2]); // R3

    AST_NO_SHORT_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_a) |=> !clk_a); // R10

endmodule

bind selclk_divbank selclk_divbank_chk #(
    .BANK_TAB (BANK_TAB),
    .FDBK_TAB (FDBK_TAB)
) u_chk (
    .clk     (div_clk),
    .rst     (mst_rst),
    .clk_a   (clk_a),
    .clk_b   (clk_b),
    .clk_fb  (clk_fb),
    .clk_ref (clk_ref)
);

// File: tb/selclk_divbank_test.sv
`timescale 1ns/1ps
module selclk_divbank_test;

    typedef struct {
        int n0;
        int n1;
        int req;
    } exp_t;

    logic       vco_clk = 1'b0;
    logic       ext_ref_clk = 1'b0;
    logic       osc_clk = 1'b0;
    logic       osc_sel = 1'b0;
    logic       pll_en = 1'b1;
    logic       mst_rst = 1'b1;
    logic [1:0] sel_a = 2'b00;
    logic [1:0] sel_b = 2'b00;
    logic [1:0] sel_fb = 2'b00;
    logic       clk_a, clk_b, clk_fb, clk_ref;
    logic [3:0] obs;
    logic       meas_clk;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t q [4][$];

    always #4  vco_clk = ~vco_clk;
    always #10 ext_ref_clk = ~ext_ref_clk;
    always #14 osc_clk = ~osc_clk;

    selclk_divbank uut (
        .vco_clk     (vco_clk),
        .ext_ref_clk (ext_ref_clk),
        .osc_clk     (osc_clk),
        .osc_sel     (osc_sel),
        .pll_en      (pll_en),
        .mst_rst     (mst_rst),
        .sel_a       (sel_a),
        .sel_b       (sel_b),
        .sel_fb      (sel_fb),
        .clk_a       (clk_a),
        .clk_b       (clk_b),
        .clk_fb      (clk_fb),
        .clk_ref     (clk_ref)
    );

    assign obs = {clk_ref, clk_fb, clk_b, clk_a};
    // Clock the requirements R6/R7 say the dividers should count.
    assign meas_clk = pll_en ? vco_clk : (osc_sel ? osc_clk : ext_ref_clk);

    function automatic int bank_n(logic [1:0] s);
        case (s)
            2'b00:   return 3;
            2'b01:   return 4;
            2'b10:   return 6;
            default: return 12;
        endcase
    endfunction

    function automatic int fdbk_n(logic [1:0] s);
        case (s)
            2'b00:   return 12;
            2'b01:   return 16;
            2'b10:   return 20;
            default: return 24;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input int o, input int n0, input int n1, input int req, input int k);
        for (int i = 0; i < k; i++) q[o].push_back('{n0, n1, req});
    endtask

    // Monitor: measures high and low runs in half-periods of meas_clk.
    initial begin
        int   run [4];
        int   hi_len [4];
        bit   started [4];
        bit   prev [4];
        exp_t e;
        for (int j = 0; j < 4; j++) begin
            run[j] = 0; hi_len[j] = 0; started[j] = 0; prev[j] = 0;
        end
        forever begin
            @(meas_clk);
            #2;
            if (mst_rst) begin
                for (int j = 0; j < 4; j++) begin
                    run[j] = 0; hi_len[j] = 0; started[j] = 0; prev[j] = 0;
                end
            end else begin
                for (int j = 0; j < 4; j++) begin
                    if (obs[j] == prev[j]) begin
                        run[j]++;
                    end else begin
                        if (prev[j]) begin
                            hi_len[j] = run[j];
                        end else begin
                            if (started[j] && q[j].size() > 0) begin
                                e = q[j].pop_front();
                                n_checks++;
                                if (!((hi_len[j] == e.n0 && run[j] == e.n0) ||
                                      (hi_len[j] == e.n1 && run[j] == e.n1))) begin
                                    n_fail++;
                                    $display("FAIL R%0d/R8 output %0d actual high=%0d low=%0d expected %0d/%0d or %0d/%0d",
                                             e.req, j, hi_len[j], run[j], e.n0, e.n0, e.n1, e.n1);
                                end
                            end
                            started[j] = 1'b1;
                        end
                        run[j]  = 1;
                        prev[j] = obs[j];
                    end
                end
            end
        end
    end

    task automatic drain(input int limit);
        for (int i = 0; i < limit; i++) begin
            if (q[0].size() == 0 && q[1].size() == 0 && q[2].size() == 0 && q[3].size() == 0) break;
            @(negedge meas_clk);
        end
        for (int j = 0; j < 4; j++) begin
            if (q[j].size() != 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R%0d output %0d actual missing=%0d periods expected 0", q[j][0].req, j, q[j].size());
                q[j].delete();
            end
        end
    endtask

    // tag 0: per-output requirement tags; otherwise one tag for all outputs.
    task automatic run_cfg(input bit pll, input bit osc, input logic [1:0] sa,
                           input logic [1:0] sb, input logic [1:0] sf, input int k, input int tag);
        @(negedge meas_clk);
        #1 mst_rst = 1'b1;
        #1 check(obs == 4'h0, "R5 outputs low on reset entry", int'(obs), 0);
        pll_en = pll;
        osc_sel = osc;
        sel_a = sa;
        sel_b = sb;
        sel_fb = sf;
        repeat (6) @(negedge meas_clk);
        #1 check(obs == 4'h0, "R5 outputs low while reset held", int'(obs), 0);
        push(0, bank_n(sa), bank_n(sa), (tag != 0) ? tag : 1, k);
        push(1, bank_n(sb), bank_n(sb), (tag != 0) ? tag : 2, k);
        push(2, fdbk_n(sf), fdbk_n(sf), (tag != 0) ? tag : 3, k);
        push(3, fdbk_n(sf), fdbk_n(sf), (tag != 0) ? tag : 4, k);
        @(negedge meas_clk);
        #1 mst_rst = 1'b0;
        @(posedge meas_clk);
        #2 check(obs == 4'hf, "R9 all outputs rise on first edge", int'(obs), 15);
    endtask

    initial begin
        // R1 R2 R3 R4 R8: every select code across the three dividers
        run_cfg(1'b1, 1'b0, 2'b00, 2'b11, 2'b00, 4, 0);
        drain(4000);
        run_cfg(1'b1, 1'b0, 2'b01, 2'b10, 2'b01, 4, 0);
        drain(4000);
        run_cfg(1'b1, 1'b0, 2'b10, 2'b00, 2'b10, 4, 0);
        drain(4000);
        run_cfg(1'b1, 1'b0, 2'b11, 2'b01, 2'b11, 4, 0);
        drain(4000);

        // R10: change bank A from divide by 3 to 12 right after a rising edge
        run_cfg(1'b1, 1'b0, 2'b00, 2'b01, 2'b00, 3, 0);
        for (int i = 0; i < 2000; i++) begin
            if (q[0].size() == 0) break;
            @(negedge meas_clk);
        end
        sel_a = 2'b11;
        push(0, 3, 3, 10, 1);
        push(0, 12, 12, 10, 3);
        drain(4000);

        // R6 R7: bypass from the external reference, then from the oscillator
        run_cfg(1'b0, 1'b0, 2'b00, 2'b10, 2'b00, 3, 6);
        drain(4000);
        run_cfg(1'b0, 1'b1, 2'b01, 2'b11, 2'b01, 3, 7);
        drain(4000);

        @(negedge meas_clk);
        #1 mst_rst = 1'b1;
        #1 check(obs == 4'h0, "R5 outputs low at final reset", int'(obs), 0);

        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule